// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a byte-wide bus write path and the controller that programs and erases a flash array. It watches every bus write (address plus data byte) and recognises the multi-cycle instructions a flash part accepts. Each instruction must begin with a two-write unlock pair. The instructions are program, erase of a chosen set of blocks, whole-array erase, identifier read, reset to array read, erase suspend and erase resume. Only the low twelve address bits take part in matching unlock and command writes. A write that breaks a sequence drops the sequencer back to array-read mode without any indication.

When an instruction completes, the block raises a one-cycle pulse for the controller. A program pulse carries the latched target address and byte. An erase pulse carries a one-hot-per-block mask. Suspend and resume requests are also single-cycle pulses. The controller ends a busy period with `op_done`. The current mode is always visible as a two-bit code. In identifier mode, a combinational read path returns the vendor code, the device code or a block's protection bit, selected by `rd_addr`.

The block address is the top `ADDR_W-BLK_SHIFT` bits of an address. The protection map comes in as a per-block input. A temporary-unprotect input overrides it for program and erase.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset `mode` is 0 (array read), `sig_data` is 00h and no pulse output is high.
- R2: The unlock pair is data AAh at low address 555h followed by data 55h at low address 2AAh. Command writes in cycle three are also matched at low address 555h. Address bits at or above bit 12 are ignored in all of these matches.
- R3: Unlock, unlock, then A0h at 555h arms a program. The next write of any address and data raises `prog_start` for one cycle, starting one clock after that write. That write's address and data appear on `prog_addr`/`prog_data`, and `mode` becomes 2 (busy).
- R4: Unlock, unlock, then 90h at 555h sets `mode` 1 (identifier). In this mode `sig_data` depends on `rd_addr`. With `rd_addr[1:0]`=00 it gives `MFR_CODE`. With 01 it gives `DEV_CODE`. With 10 and `rd_addr[6]`=0 it gives 01h if that address's block is marked in `prot_map`, else 00h. All other cases give 00h. Outside mode 1, `sig_data` is 00h.
- R5: Data F0h, written either alone or after the unlock pair, returns `mode` to 0 from identifier mode. It has no effect while an erase is busy or suspended.
- R6: Any write that is not the expected next step of a sequence returns the sequencer to its first step. It also leaves identifier mode, so `mode` reads 0 when not busy or suspended, and no operation starts.
- R7: Unlock, unlock, 80h at 555h, unlock, unlock, then 10h at 555h raises `erase_start` one clock later. `erase_mask` then has a 1 for every block that is not effectively protected, and `mode` becomes 2.
- R8: Data 30h in cycle six selects the block of its address and opens a collection window of `WIN_CYC` clocks. Each further 30h write in the window adds its block and restarts the window. `erase_start` rises exactly `WIN_CYC` clocks after the last such write. Any other write during the window cancels the erase.
- R9: While busy, writes are ignored, with one exception: B0h during an erase raises `susp_req` for one cycle and sets `mode` 3 (suspended). B0h during a program is ignored.
- R10: In mode 3, a program sequence to a block outside `erase_mask` is accepted. A program to a block inside the mask is dropped. A single 30h write raises `resume_req` and returns `mode` to 2.
- R11: A block is effectively protected when its `prot_map` bit is 1 and `unprot_temp` is 0. A program aimed at such a block is dropped. Such a block is never added to an erase mask. An erase whose mask ends up empty is dropped.
- R12: `op_done` in busy mode ends the operation. After a program, `mode` becomes 3 if an erase is suspended, else 0. After an erase, `mode` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One bus write this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | ADDR_W | Read address for identifier data |
| prot_map | input | 2**(ADDR_W-BLK_SHIFT) | Per-block protection flags |
| unprot_temp | input | 1 | Temporary override of protection |
| op_done | input | 1 | Controller finished the running operation |
| mode | output | 2 | 0 array, 1 identifier, 2 busy, 3 erase suspended |
| prog_start | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | 8 | Program data byte |
| erase_start | output | 1 | One-cycle erase request |
| erase_mask | output | 2**(ADDR_W-BLK_SHIFT) | Blocks to erase, valid with erase_start and held through suspend |
| susp_req | output | 1 | One-cycle erase suspend request |
| resume_req | output | 1 | One-cycle erase resume request |
| sig_data | output | 8 | Identifier read data |

## Verification
The bench builds the block with `ADDR_W`=16, `BLK_SHIFT`=12 and `WIN_CYC`=8. This gives sixteen 4 KB blocks, so the block index, the protection map and the erase masks are small enough to state exactly in the checks. The short window lets the bench count clocks after each block-erase confirm. It can then show that the start is neither early nor late, and that a stray write inside the window cancels the erase. `DEV_CODE` is set apart from the default so the identifier path is shown to follow the parameter.

// File: rtl/flash_cmd_seq_pkg.sv
package flash_cmd_seq_pkg;

   localparam int KEY_W = 12;

   localparam logic [KEY_W-1:0] KEY_ADR_A = 12'h555;
   localparam logic [KEY_W-1:0] KEY_ADR_B = 12'h2AA;
   localparam logic [7:0]       KEY_DAT_A = 8'hAA;
   localparam logic [7:0]       KEY_DAT_B = 8'h55;

   localparam logic [7:0] OP_PROG   = 8'hA0;
   localparam logic [7:0] OP_IDENT  = 8'h90;
   localparam logic [7:0] OP_ERASE  = 8'h80;
   localparam logic [7:0] OP_CHIP   = 8'h10;
   localparam logic [7:0] OP_BLOCK  = 8'h30;
   localparam logic [7:0] OP_SUSP   = 8'hB0;
   localparam logic [7:0] OP_RESUME = 8'h30;

   typedef enum logic [1:0] {
      MD_ARRAY = 2'd0,
      MD_IDENT = 2'd1,
      MD_BUSY  = 2'd2,
      MD_SUSP  = 2'd3
   } ci_mode_e;

   typedef enum logic [3:0] {
      ST_READ,
      ST_KEY1,
      ST_KEY2,
      ST_PADDR,
      ST_ERS3,
      ST_ERS4,
      ST_ERS5,
      ST_EWIN,
      ST_PGBUSY,
      ST_ERBUSY
   } ci_state_e;

endpackage

// File: rtl/fcs_key_match.sv
module fcs_key_match
   import flash_cmd_seq_pkg::*;
#(
   parameter int KW = KEY_W
) (
   input  logic [KW-1:0] adr_lo,
   input  logic [7:0]    dat,
   output logic          hit_a,
   output logic          hit_b,
   output logic          at_cmd
);
   localparam logic [KW-1:0] ADR_A = KW'(KEY_ADR_A);
   localparam logic [KW-1:0] ADR_B = KW'(KEY_ADR_B);

   assign at_cmd = (adr_lo == ADR_A);
   assign hit_a  = at_cmd && (dat == KEY_DAT_A);
   assign hit_b  = (adr_lo == ADR_B) && (dat == KEY_DAT_B);
endmodule

// File: rtl/fcs_block_decode.sv
module fcs_block_decode #(
   parameter int BW   = 4,
   parameter int NBLK = 1 << BW
) (
   input  logic [BW-1:0]   blk_idx,
   input  logic [NBLK-1:0] prot_map,
   input  logic            unprot_temp,
   output logic [NBLK-1:0] blk_hot,
   output logic [NBLK-1:0] eff_prot,
   output logic            blk_locked
);
   for (genvar i = 0; i < NBLK; i++) begin : g_blk
      assign blk_hot[i]  = (blk_idx == BW'(i));
      assign eff_prot[i] = prot_map[i] & ~unprot_temp;
   end

   assign blk_locked = |(blk_hot & eff_prot);
endmodule

// File: rtl/fcs_ident_mux.sv
module fcs_ident_mux #(
   parameter int          ADDR_W    = 20,
   parameter int          BLK_SHIFT = 16,
   parameter logic [7:0]  MFR_CODE  = 8'h20,
   parameter logic [7:0]  DEV_CODE  = 8'hA7,
   localparam int         NBLK      = 1 << (ADDR_W - BLK_SHIFT)
) (
   input  logic              active,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [NBLK-1:0]   prot_map,
   output logic [7:0]        sig_data
);
   logic unused_mid;
   assign unused_mid = ^{rd_addr[BLK_SHIFT-1:7], rd_addr[5:2]};

   always_comb begin
      sig_data = 8'h00;
      if (active) begin
         unique case (rd_addr[1:0])
            2'b00:   sig_data = MFR_CODE;
            2'b01:   sig_data = DEV_CODE;
            2'b10:   if (!rd_addr[6])
                        sig_data = {7'd0, prot_map[rd_addr[ADDR_W-1:BLK_SHIFT]]};
            default: sig_data = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import flash_cmd_seq_pkg::*;
#(
   parameter int         ADDR_W    = 20,
   parameter int         BLK_SHIFT = 16,
   parameter int         WIN_CYC   = 32,
   parameter logic [7:0] MFR_CODE  = 8'h20,
   parameter logic [7:0] DEV_CODE  = 8'hA7,
   localparam int        BW        = ADDR_W - BLK_SHIFT,
   localparam int        NBLK      = 1 << BW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [NBLK-1:0]   prot_map,
   input  logic              unprot_temp,
   input  logic              op_done,
   output logic [1:0]        mode,
   output logic              prog_start,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [7:0]        prog_data,
   output logic              erase_start,
   output logic [NBLK-1:0]   erase_mask,
   output logic              susp_req,
   output logic              resume_req,
   output logic [7:0]        sig_data
);
   localparam int CW = $clog2(WIN_CYC + 1);
   localparam logic [CW-1:0] WIN_RELOAD = CW'(WIN_CYC - 1);

   if (ADDR_W < KEY_W) begin : g_bad_addr
      $error("ADDR_W must cover the key address bits");
   end
   if (BLK_SHIFT < 8 || BLK_SHIFT >= ADDR_W) begin : g_bad_shift
      $error("BLK_SHIFT must lie in 8..ADDR_W-1");
   end
   if (BW > 10) begin : g_bad_blocks
      $error("at most 1024 blocks");
   end
   if (WIN_CYC < 1) begin : g_bad_win
      $error("WIN_CYC must be at least 1");
   end

   logic            hit_a, hit_b, at_cmd, blk_locked;
   logic [NBLK-1:0] blk_hot, eff_prot;

   fcs_key_match #(.KW(KEY_W)) u_key (
      .adr_lo (wr_addr[KEY_W-1:0]),
      .dat    (wr_data),
      .hit_a  (hit_a),
      .hit_b  (hit_b),
      .at_cmd (at_cmd)
   );

   fcs_block_decode #(.BW(BW), .NBLK(NBLK)) u_blk (
      .blk_idx     (wr_addr[ADDR_W-1:BLK_SHIFT]),
      .prot_map    (prot_map),
      .unprot_temp (unprot_temp),
      .blk_hot     (blk_hot),
      .eff_prot    (eff_prot),
      .blk_locked  (blk_locked)
   );

   ci_state_e         st_q;
   logic              ident_q, susp_q;
   logic [NBLK-1:0]   mask_q;
   logic [CW-1:0]     win_q;
   logic [ADDR_W-1:0] pa_q;
   logic [7:0]        pd_q;
   logic              pstart_q, estart_q, sreq_q, rreq_q;
   ci_mode_e          mode_e;

   logic [NBLK-1:0] new_blk;
   logic            prog_ok;
   assign new_blk = blk_hot & ~eff_prot;
   assign prog_ok = !blk_locked && !(susp_q && |(blk_hot & mask_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_READ;
         ident_q  <= 1'b0;
         susp_q   <= 1'b0;
         mask_q   <= '0;
         win_q    <= '0;
         pa_q     <= '0;
         pd_q     <= '0;
         pstart_q <= 1'b0;
         estart_q <= 1'b0;
         sreq_q   <= 1'b0;
         rreq_q   <= 1'b0;
      end else begin
         pstart_q <= 1'b0;
         estart_q <= 1'b0;
         sreq_q   <= 1'b0;
         rreq_q   <= 1'b0;
         unique case (st_q)
            ST_READ: if (wr_en) begin
               if (hit_a) st_q <= ST_KEY1;
               else if (susp_q && wr_data == OP_RESUME) begin
                  susp_q <= 1'b0;
                  rreq_q <= 1'b1;
                  st_q   <= ST_ERBUSY;
               end else if (!susp_q) ident_q <= 1'b0;
            end
            ST_KEY1: if (wr_en) begin
               if (hit_b) st_q <= ST_KEY2;
               else begin
                  st_q <= ST_READ;
                  if (!susp_q) ident_q <= 1'b0;
               end
            end
            ST_KEY2: if (wr_en) begin
               st_q <= ST_READ;
               if (at_cmd && wr_data == OP_PROG) st_q <= ST_PADDR;
               else if (at_cmd && !susp_q && wr_data == OP_IDENT) ident_q <= 1'b1;
               else if (at_cmd && !susp_q && wr_data == OP_ERASE) st_q <= ST_ERS3;
               else if (!susp_q) ident_q <= 1'b0;
            end
            ST_PADDR: if (wr_en) begin
               st_q <= ST_READ;
               if (!susp_q) ident_q <= 1'b0;
               if (prog_ok) begin
                  pa_q     <= wr_addr;
                  pd_q     <= wr_data;
                  pstart_q <= 1'b1;
                  st_q     <= ST_PGBUSY;
               end
            end
            ST_ERS3: if (wr_en) begin
               if (hit_a) st_q <= ST_ERS4;
               else begin st_q <= ST_READ; ident_q <= 1'b0; end
            end
            ST_ERS4: if (wr_en) begin
               if (hit_b) st_q <= ST_ERS5;
               else begin st_q <= ST_READ; ident_q <= 1'b0; end
            end
            ST_ERS5: if (wr_en) begin
               st_q    <= ST_READ;
               ident_q <= 1'b0;
               if (at_cmd && wr_data == OP_CHIP) begin
                  if (|(~eff_prot)) begin
                     mask_q   <= ~eff_prot;
                     estart_q <= 1'b1;
                     st_q     <= ST_ERBUSY;
                  end
               end else if (wr_data == OP_BLOCK) begin
                  mask_q <= new_blk;
                  win_q  <= WIN_RELOAD;
                  st_q   <= ST_EWIN;
               end
            end
            ST_EWIN: begin
               if (wr_en) begin
                  if (wr_data == OP_BLOCK) begin
                     mask_q <= mask_q | new_blk;
                     win_q  <= WIN_RELOAD;
                  end else begin
                     st_q   <= ST_READ;
                     mask_q <= '0;
                  end
               end else if (win_q == '0) begin
                  st_q <= ST_READ;
                  if (|mask_q) begin
                     estart_q <= 1'b1;
                     st_q     <= ST_ERBUSY;
                  end
               end else begin
                  win_q <= win_q - 1'b1;
               end
            end
            ST_PGBUSY: if (op_done) st_q <= ST_READ;
            ST_ERBUSY: begin
               if (op_done) begin
                  st_q   <= ST_READ;
                  mask_q <= '0;
               end else if (wr_en && wr_data == OP_SUSP) begin
                  susp_q <= 1'b1;
                  sreq_q <= 1'b1;
                  st_q   <= ST_READ;
               end
            end
            default: st_q <= ST_READ;
         endcase
      end
   end

   always_comb begin
      if (st_q == ST_PGBUSY || st_q == ST_ERBUSY) mode_e = MD_BUSY;
      else if (susp_q)                             mode_e = MD_SUSP;
      else if (ident_q)                            mode_e = MD_IDENT;
      else                                         mode_e = MD_ARRAY;
   end

   fcs_ident_mux #(
      .ADDR_W    (ADDR_W),
      .BLK_SHIFT (BLK_SHIFT),
      .MFR_CODE  (MFR_CODE),
      .DEV_CODE  (DEV_CODE)
   ) u_ident (
      .active   (mode_e == MD_IDENT),
      .rd_addr  (rd_addr),
      .prot_map (prot_map),
      .sig_data (sig_data)
   );

   assign mode        = mode_e;
   assign prog_start  = pstart_q;
   assign prog_addr   = pa_q;
   assign prog_data   = pd_q;
   assign erase_start = estart_q;
   assign erase_mask  = mask_q;
   assign susp_req    = sreq_q;
   assign resume_req  = rreq_q;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       op_done,
   input logic [1:0] mode,
   input logic       prog_start,
   input logic       erase_start,
   input logic       susp_req,
   input logic       resume_req,
   input logic [7:0] sig_data
);
   a_r1_reset_array: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mode == 2'd0 && !prog_start && !erase_start));

   a_r3_prog_busy: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> mode == 2'd2);

   a_r7_erase_busy: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |-> mode == 2'd2);

   a_r9_no_start_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_start || erase_start) |-> $past(mode) != 2'd2);

   a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && !op_done && !wr_en) |=> mode == 2'd2);

   a_r9_suspend_mode: assert property (@(posedge clk) disable iff (!rst_n)
      susp_req |-> mode == 2'd3);

   a_r10_resume_mode: assert property (@(posedge clk) disable iff (!rst_n)
      resume_req |-> mode == 2'd2);

   a_r12_done_leaves_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && op_done) |=> mode != 2'd2);

   a_r4_ident_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'd1 |-> sig_data == 8'h00);

   a_r9_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({prog_start, erase_start, susp_req, resume_req}) <= 1);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .op_done     (op_done),
   .mode        (mode),
   .prog_start  (prog_start),
   .erase_start (erase_start),
   .susp_req    (susp_req),
   .resume_req  (resume_req),
   .sig_data    (sig_data)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
   localparam int AW   = 16;
   localparam int BS   = 12;
   localparam int WIN  = 8;
   localparam int NB   = 1 << (AW - BS);
   localparam logic [7:0] MFR = 8'h20;
   localparam logic [7:0] DEV = 8'hC5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [NB-1:0] prot_map = 16'h0008;
   logic          unprot_temp = 1'b0;
   logic          op_done = 1'b0;
   logic [1:0]    mode;
   logic          prog_start, erase_start, susp_req, resume_req;
   logic [AW-1:0] prog_addr;
   logic [7:0]    prog_data, sig_data;
   logic [NB-1:0] erase_mask;

   always #10 clk = ~clk;

   flash_cmd_seq #(
      .ADDR_W(AW), .BLK_SHIFT(BS), .WIN_CYC(WIN), .MFR_CODE(MFR), .DEV_CODE(DEV)
   ) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .prot_map(prot_map), .unprot_temp(unprot_temp),
      .op_done(op_done), .mode(mode), .prog_start(prog_start), .prog_addr(prog_addr),
      .prog_data(prog_data), .erase_start(erase_start), .erase_mask(erase_mask),
      .susp_req(susp_req), .resume_req(resume_req), .sig_data(sig_data)
   );

   typedef struct {
      int          kind;   // 0 program, 1 erase, 2 suspend, 3 resume
      logic [15:0] addr;
      logic [7:0]  data;
      logic [15:0] mask;
      string       tag;
   } ev_t;

   ev_t exp_q[$];
   int  n_chk  = 0;
   int  n_fail = 0;
   bit  ended  = 1'b0;

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(input int k, input logic [15:0] a, input logic [7:0] d,
                       input logic [15:0] m, input string tag);
      ev_t e;
      e.kind = k; e.addr = a; e.data = d; e.mask = m; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic unlock();
      wr(16'h0555, 8'hAA);
      wr(16'h02AA, 8'h55);
   endtask

   task automatic prog(input logic [15:0] a, input logic [7:0] d);
      unlock();
      wr(16'h0555, 8'hA0);
      wr(a, d);
   endtask

   task automatic erase_head();
      unlock();
      wr(16'h0555, 8'h80);
      unlock();
   endtask

   task automatic done_pulse();
      @(negedge clk);
      op_done = 1'b1;
      @(negedge clk);
      op_done = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Monitor: pops the scoreboard on every request pulse
   always @(negedge clk) begin
      if (rst_n && (prog_start || erase_start || susp_req || resume_req)) begin
         int k;
         ev_t e;
         k = prog_start ? 0 : erase_start ? 1 : susp_req ? 2 : 3;
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R6 unexpected event kind actual=%0d expected=none", k);
         end else begin
            e = exp_q.pop_front();
            if (e.kind != k) begin
               n_fail++;
               $display("FAIL %s event kind actual=%0d expected=%0d", e.tag, k, e.kind);
            end else if (k == 0 && (prog_addr !== e.addr || prog_data !== e.data)) begin
               n_fail++;
               $display("FAIL %s program actual=%0h/%0h expected=%0h/%0h",
                        e.tag, prog_addr, prog_data, e.addr, e.data);
            end else if (k == 1 && erase_mask !== e.mask) begin
               n_fail++;
               $display("FAIL %s erase mask actual=%0h expected=%0h", e.tag, erase_mask, e.mask);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1: reset state
      chk("R1 mode", mode, 0);
      chk("R1 sig_data", sig_data, 0);

      // R2 upper address bits ignored; R3 program start
      wr(16'hF555, 8'hAA);
      wr(16'hF2AA, 8'h55);
      wr(16'h8555, 8'hA0);
      push(0, 16'h1234, 8'h5A, 0, "R3");
      wr(16'h1234, 8'h5A);
      chk("R3 busy", mode, 2);
      // R9 writes ignored during program, including suspend
      wr(16'h0000, 8'hB0);
      chk("R9 B0 ignored in program", mode, 2);
      wr(16'h0000, 8'hF0);
      chk("R9 F0 ignored in program", mode, 2);
      done_pulse();
      chk("R12 program done", mode, 0);

      // R4 identifier reads
      unlock();
      wr(16'h0555, 8'h90);
      chk("R4 mode", mode, 1);
      rd_addr = 16'h0000; #1 chk("R4 mfr", sig_data, MFR);
      rd_addr = 16'h0001; #1 chk("R4 dev", sig_data, DEV);
      rd_addr = 16'h3002; #1 chk("R4 prot set", sig_data, 1);
      rd_addr = 16'h4002; #1 chk("R4 prot clear", sig_data, 0);
      rd_addr = 16'h3042; #1 chk("R4 A6 high", sig_data, 0);
      rd_addr = 16'h0003; #1 chk("R4 other", sig_data, 0);
      // R5 single-cycle reset
      wr(16'h0000, 8'hF0);
      chk("R5 F0 alone", mode, 0);
      rd_addr = 16'h0000; #1 chk("R4 quiet outside mode", sig_data, 0);
      unlock();
      wr(16'h0555, 8'h90);
      unlock();
      wr(16'h0555, 8'hF0);
      chk("R5 F0 after unlock", mode, 0);

      // R6 broken sequences
      unlock();
      wr(16'h0555, 8'h90);
      wr(16'h0555, 8'h12);
      chk("R6 junk leaves ident", mode, 0);
      wr(16'h0555, 8'hAA);
      wr(16'h02AA, 8'h12);
      chk("R6 bad second key", mode, 0);
      unlock();
      wr(16'h0444, 8'hA0);
      wr(16'h5000, 8'h11);
      chk("R6 wrong command address", mode, 0);
      push(0, 16'h2100, 8'h3C, 0, "R6 restart");
      prog(16'h2100, 8'h3C);
      chk("R6 program after abort", mode, 2);
      done_pulse();

      // R11 protection on program
      prog(16'h3010, 8'h77);
      chk("R11 program dropped", mode, 0);
      unprot_temp = 1'b1;
      push(0, 16'h3010, 8'h77, 0, "R11 override");
      prog(16'h3010, 8'h77);
      chk("R11 override busy", mode, 2);
      done_pulse();
      unprot_temp = 1'b0;

      // R7 chip erase
      erase_head();
      push(1, 0, 0, 16'hFFF7, "R7");
      wr(16'h0555, 8'h10);
      chk("R7 busy", mode, 2);
      wr(16'h0000, 8'hF0);
      chk("R5 F0 refused in erase", mode, 2);
      // R9 suspend
      push(2, 0, 0, 0, "R9");
      wr(16'h0000, 8'hB0);
      chk("R9 suspended", mode, 3);
      // R10 program in suspend
      prog(16'h5000, 8'h01);
      chk("R10 program to erasing block dropped", mode, 3);
      unprot_temp = 1'b1;
      push(0, 16'h3020, 8'h0F, 0, "R10 program in suspend");
      prog(16'h3020, 8'h0F);
      chk("R10 suspend program busy", mode, 2);
      done_pulse();
      unprot_temp = 1'b0;
      chk("R12 back to suspend", mode, 3);
      wr(16'h0000, 8'hF0);
      chk("R5 F0 refused in suspend", mode, 3);
      push(3, 0, 0, 0, "R10 resume");
      wr(16'h0000, 8'h30);
      chk("R10 resumed", mode, 2);
      done_pulse();
      chk("R12 erase done", mode, 0);

      // R8 multi-block erase and window timing
      erase_head();
      wr(16'h1000, 8'h30);
      wr(16'h6ABC, 8'h30);
      push(1, 0, 0, 16'h0042, "R8");
      wr(16'h3000, 8'h30);
      idle(WIN - 1);
      chk("R8 not early", mode, 0);
      idle(1);
      chk("R8 on time", mode, 2);
      done_pulse();

      // R8 abort within window
      erase_head();
      wr(16'h2000, 8'h30);
      wr(16'h2000, 8'h55);
      idle(WIN + 4);
      chk("R8 abort", mode, 0);

      // R11 erase of protected block only
      erase_head();
      wr(16'h3000, 8'h30);
      idle(WIN + 4);
      chk("R11 empty erase dropped", mode, 0);

      idle(2);
      chk("R3 R7 scoreboard drained", exp_q.size(), 0);
      finish_run();
   end
endmodule